// File: doc/BRIEF.md
# In-Order Dual-Issue Pairing Checker

This block sits between an instruction queue and two execution slots of an in-order pipeline. In every cycle it looks at the two oldest decoded instructions, the older in slot 0 and the younger in slot 1, and decides how many of them leave the queue. Only two outcomes are possible: both instructions issue together, or only the older one issues. Program order is never broken. Slot 1 never issues on its own, and it never issues ahead of a stalled slot 0.

Two instructions may issue together only when the older one is a memory access (a load or a store) and the younger one is an integer operation. The two must also be independent. The block checks the register numbers of the pair, and it keeps a short record of loads that have just issued. An instruction that reads a register still being loaded waits until the load result is ready. The pop count goes straight to the queue as its pop amount.

Top module: `pair_issue_top`

## Requirements
- R1: An asynchronous active-low reset clears the record of recent loads. A consumer of a register loaded just before reset issues while reset is held.
- R2: While `stall` is high, neither slot issues and `pop_count` is 0.
- R3: If slot 0 is invalid, neither slot issues, whatever slot 1 holds.
- R4: If slot 1 is invalid, at most slot 0 issues.
- R5: Class codes are 2'b00 integer, 2'b01 load and 2'b10 store. Slot 1 issues only when slot 0 is a load or a store and slot 1 is an integer operation. Every other class combination issues slot 0 alone.
- R6: If slot 0 is a load with a nonzero destination that equals either source of slot 1, only slot 0 issues. A destination of register 0 never creates a dependence.
- R7: If slot 0 is a load and both slots write the same nonzero destination, only slot 0 issues. If both destinations are register 0, the pair still issues.
- R8: `issue1` is never high unless `issue0` is high.
- R9: An instruction that reads the nonzero destination of a load issued within the last `LOAD_GAP` cycles does not issue (default `LOAD_GAP` is 1). If slot 0 is blocked this way, slot 1 does not issue either. If only slot 1 is blocked, slot 0 issues alone.
- R10: `pop_count` equals the number of issue signals that are high (0, 1 or 2).
- R11: The load-use block ends exactly `LOAD_GAP` cycles after the load issued, and cycles spent in stall count toward that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Pipeline stall; blocks all issue |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 2 | Slot 0 class: 00 integer, 01 load, 10 store |
| s0_dst | input | REG_W | Slot 0 destination register |
| s0_src_a | input | REG_W | Slot 0 first source register |
| s0_src_b | input | REG_W | Slot 0 second source register |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 2 | Slot 1 class, same encoding as slot 0 |
| s1_dst | input | REG_W | Slot 1 destination register |
| s1_src_a | input | REG_W | Slot 1 first source register |
| s1_src_b | input | REG_W | Slot 1 second source register |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| pop_count | output | 2 | Number of instructions consumed |

## Verification
The pairing decision is combinational, so a wrong class or register comparison shows up on `issue1` and `pop_count` in the same cycle the pair is presented. The only internal state is the record of recent loads. If that record is wrong, the mistake shows up only when a consumer of the loaded register appears. A missing or stale entry then produces an issue that comes one cycle too early or too late. For this reason the tests place consumers in exactly the cycles right after a load, after a stall, and across a reset.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

  typedef enum logic [1:0] {
    CLS_INT   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10
  } op_cls_e;

  function automatic logic cls_is_mem(input logic [1:0] cls);
    return (cls == CLS_LOAD) || (cls == CLS_STORE);
  endfunction

  function automatic logic cls_writes(input logic [1:0] cls);
    return (cls == CLS_LOAD) || (cls == CLS_INT);
  endfunction

endpackage

// File: rtl/pair_hazard_cmp.sv
module pair_hazard_cmp
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [1:0]       s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [1:0]       s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [REG_W-1:0] s1_src_a,
  input  logic [REG_W-1:0] s1_src_b,
  output logic             class_ok,
  output logic             raw_hit,
  output logic             waw_hit
);

  logic s0_wr;
  logic s1_wr;

  always_comb begin
    s0_wr    = cls_writes(s0_cls) && (s0_dst != '0);
    s1_wr    = cls_writes(s1_cls) && (s1_dst != '0);
    class_ok = cls_is_mem(s0_cls) && (s1_cls == CLS_INT);
    raw_hit  = s0_wr && ((s0_dst == s1_src_a) || (s0_dst == s1_src_b));
    waw_hit  = s0_wr && s1_wr && (s0_dst == s1_dst);
  end

endmodule

// File: rtl/load_shadow.sv
module load_shadow #(
  parameter int REG_W    = 5,
  parameter int LOAD_GAP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_issued,
  input  logic [REG_W-1:0] load_dst,
  input  logic [REG_W-1:0] q0_src_a,
  input  logic [REG_W-1:0] q0_src_b,
  input  logic [REG_W-1:0] q1_src_a,
  input  logic [REG_W-1:0] q1_src_b,
  output logic             hit0,
  output logic             hit1
);

  logic [LOAD_GAP-1:0]            ent_vld_q, ent_vld_d;
  logic [LOAD_GAP-1:0][REG_W-1:0] ent_dst_q, ent_dst_d;
  logic [LOAD_GAP-1:0]            hit0_vec, hit1_vec;
  logic                           shift_en;

  // next state: newest load enters at index 0, entries age by one per cycle
  always_comb begin
    shift_en     = load_issued || (|ent_vld_q);
    ent_vld_d[0] = load_issued && (load_dst != '0);
    ent_dst_d[0] = load_dst;
    for (int i = 1; i < LOAD_GAP; i++) begin
      ent_vld_d[i] = ent_vld_q[i-1];
      ent_dst_d[i] = ent_dst_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld_q <= '0;
      ent_dst_q <= '0;
    end else if (shift_en) begin
      ent_vld_q <= ent_vld_d;
      ent_dst_q <= ent_dst_d;
    end
  end

  for (genvar g = 0; g < LOAD_GAP; g++) begin : g_cmp
    assign hit0_vec[g] = ent_vld_q[g] &&
                         ((ent_dst_q[g] == q0_src_a) || (ent_dst_q[g] == q0_src_b));
    assign hit1_vec[g] = ent_vld_q[g] &&
                         ((ent_dst_q[g] == q1_src_a) || (ent_dst_q[g] == q1_src_b));
  end

  assign hit0 = |hit0_vec;
  assign hit1 = |hit1_vec;

endmodule

// File: rtl/pair_issue_top.sv
module pair_issue_top
  import pair_issue_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int LOAD_GAP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             s0_valid,
  input  logic [1:0]       s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [REG_W-1:0] s0_src_a,
  input  logic [REG_W-1:0] s0_src_b,
  input  logic             s1_valid,
  input  logic [1:0]       s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [REG_W-1:0] s1_src_a,
  input  logic [REG_W-1:0] s1_src_b,
  output logic             issue0,
  output logic             issue1,
  output logic [1:0]       pop_count
);

  logic class_ok, raw_hit, waw_hit;
  logic shadow0, shadow1;
  logic pair_ok;

  pair_hazard_cmp #(.REG_W(REG_W)) u_cmp (
    .s0_cls   (s0_cls),
    .s0_dst   (s0_dst),
    .s1_cls   (s1_cls),
    .s1_dst   (s1_dst),
    .s1_src_a (s1_src_a),
    .s1_src_b (s1_src_b),
    .class_ok (class_ok),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit)
  );

  load_shadow #(.REG_W(REG_W), .LOAD_GAP(LOAD_GAP)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_issued (issue0 && (s0_cls == CLS_LOAD)),
    .load_dst    (s0_dst),
    .q0_src_a    (s0_src_a),
    .q0_src_b    (s0_src_b),
    .q1_src_a    (s1_src_a),
    .q1_src_b    (s1_src_b),
    .hit0        (shadow0),
    .hit1        (shadow1)
  );

  always_comb begin
    issue0    = !stall && s0_valid && !shadow0;
    pair_ok   = s1_valid && class_ok && !raw_hit && !waw_hit && !shadow1;
    issue1    = issue0 && pair_ok;
    pop_count = {1'b0, issue0} + {1'b0, issue1};
  end

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             s0_valid,
  input logic [1:0]       s0_cls,
  input logic [REG_W-1:0] s0_dst,
  input logic [REG_W-1:0] s0_src_a,
  input logic [REG_W-1:0] s0_src_b,
  input logic             s1_valid,
  input logic [1:0]       s1_cls,
  input logic [REG_W-1:0] s1_dst,
  input logic [REG_W-1:0] s1_src_a,
  input logic [REG_W-1:0] s1_src_b,
  input logic             issue0,
  input logic             issue1,
  input logic [1:0]       pop_count
);

  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!issue0 && !issue1));

  a_r3_no_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_valid |-> (!issue0 && !issue1));

  a_r4_no_slot1: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |-> !issue1);

  a_r5_pair_class: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> ((s0_cls == CLS_LOAD || s0_cls == CLS_STORE) && s1_cls == CLS_INT));

  a_r6_no_raw_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_cls == CLS_LOAD && s0_dst != '0 &&
     (s0_dst == s1_src_a || s0_dst == s1_src_b)) |-> !issue1);

  a_r7_no_waw_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_cls == CLS_LOAD && s0_dst != '0 && s1_dst == s0_dst) |-> !issue1);

  a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> issue0);

  a_r9_load_use_s0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue0 && s0_cls == CLS_LOAD && s0_dst != '0) &&
     (s0_src_a == $past(s0_dst) || s0_src_b == $past(s0_dst))) |-> !issue0);

  a_r9_load_use_s1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue0 && s0_cls == CLS_LOAD && s0_dst != '0) &&
     (s1_src_a == $past(s0_dst) || s1_src_b == $past(s0_dst))) |-> !issue1);

  a_r10_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    pop_count == $countones({issue0, issue1}));

endmodule

bind pair_issue_top pair_issue_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/pair_issue_top_tb.sv
module pair_issue_top_tb_top;

  localparam int REG_W = 5;
  localparam logic [1:0] INT = 2'b00, LD = 2'b01, ST = 2'b10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stall;
  logic             s0_valid, s1_valid;
  logic [1:0]       s0_cls, s1_cls;
  logic [REG_W-1:0] s0_dst, s0_src_a, s0_src_b;
  logic [REG_W-1:0] s1_dst, s1_src_a, s1_src_b;
  logic             issue0, issue1;
  logic [1:0]       pop_count;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pair_issue_top #(.REG_W(REG_W), .LOAD_GAP(1)) dut_i (
    .clk, .rst_n, .stall,
    .s0_valid, .s0_cls, .s0_dst, .s0_src_a, .s0_src_b,
    .s1_valid, .s1_cls, .s1_dst, .s1_src_a, .s1_src_b,
    .issue0, .issue1, .pop_count
  );

  task automatic set0(input logic v, input logic [1:0] c, input int d, input int a, input int b);
    s0_valid = v; s0_cls = c; s0_dst = REG_W'(d); s0_src_a = REG_W'(a); s0_src_b = REG_W'(b);
  endtask

  task automatic set1(input logic v, input logic [1:0] c, input int d, input int a, input int b);
    s1_valid = v; s1_cls = c; s1_dst = REG_W'(d); s1_src_a = REG_W'(a); s1_src_b = REG_W'(b);
  endtask

  // wait to the falling edge so new inputs settle away from the active edge
  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic expect_issue(input string tag, input logic e0, input logic e1);
    logic [1:0] ecnt;
    #1;
    ecnt = {1'b0, e0} + {1'b0, e1};
    checks++;
    if (issue0 !== e0 || issue1 !== e1 || pop_count !== ecnt) begin
      failures++;
      $display("FAIL %s: issue0=%b issue1=%b pop=%0d expected %b %b %0d",
               tag, issue0, issue1, pop_count, e0, e1, ecnt);
    end
  endtask

  task automatic idle();
    next_cycle();
    stall = 1'b0;
    set0(1'b0, INT, 0, 0, 0);
    set1(1'b0, INT, 0, 0, 0);
  endtask

  task automatic t_reset_state();
    idle();
    expect_issue("R1 reset idle", 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    idle();
    stall = 1'b1;
    set0(1'b1, LD, 3, 1, 0); set1(1'b1, INT, 4, 2, 2);
    expect_issue("R2 stall blocks pair", 1'b0, 1'b0);
    idle();
  endtask

  task automatic t_invalid_slots();
    idle();
    set0(1'b0, ST, 0, 1, 2); set1(1'b1, INT, 4, 2, 2);
    expect_issue("R3 invalid slot0", 1'b0, 1'b0);
    idle();
    set0(1'b1, ST, 0, 1, 2); set1(1'b0, INT, 4, 2, 2);
    expect_issue("R4 invalid slot1", 1'b1, 1'b0);
  endtask

  task automatic t_classes();
    idle(); set0(1'b1, ST, 0, 1, 2);   set1(1'b1, INT, 4, 2, 3);
    expect_issue("R5 store+int pairs", 1'b1, 1'b1);
    idle(); set0(1'b1, LD, 9, 1, 0);   set1(1'b1, INT, 4, 2, 3);
    expect_issue("R5 load+int pairs", 1'b1, 1'b1);
    idle(); set0(1'b1, INT, 9, 1, 2);  set1(1'b1, INT, 4, 2, 3);
    expect_issue("R5 int+int single", 1'b1, 1'b0);
    idle(); set0(1'b1, INT, 9, 1, 2);  set1(1'b1, LD, 4, 2, 0);
    expect_issue("R5 R8 int+load single", 1'b1, 1'b0);
    idle(); set0(1'b1, LD, 9, 1, 0);   set1(1'b1, ST, 0, 2, 3);
    expect_issue("R5 load+store single", 1'b1, 1'b0);
  endtask

  task automatic t_raw();
    idle(); set0(1'b1, LD, 6, 1, 0); set1(1'b1, INT, 7, 6, 2);
    expect_issue("R6 raw on src_a", 1'b1, 1'b0);
    idle(); set0(1'b1, LD, 6, 1, 0); set1(1'b1, INT, 7, 2, 6);
    expect_issue("R6 raw on src_b", 1'b1, 1'b0);
    idle(); set0(1'b1, LD, 0, 1, 0); set1(1'b1, INT, 7, 0, 0);
    expect_issue("R6 r0 not a dependence", 1'b1, 1'b1);
    idle(); set0(1'b1, ST, 0, 6, 8); set1(1'b1, INT, 7, 6, 8);
    expect_issue("R6 store shares sources", 1'b1, 1'b1);
  endtask

  task automatic t_waw();
    idle(); set0(1'b1, LD, 11, 1, 0); set1(1'b1, INT, 11, 2, 3);
    expect_issue("R7 waw blocks", 1'b1, 1'b0);
    idle(); set0(1'b1, LD, 0, 1, 0);  set1(1'b1, INT, 0, 2, 3);
    expect_issue("R7 both r0 pairs", 1'b1, 1'b1);
  endtask

  task automatic t_load_use();
    idle(); set0(1'b1, LD, 12, 1, 0); set1(1'b0, INT, 0, 0, 0);
    expect_issue("R9 load issues", 1'b1, 1'b0);
    next_cycle(); set0(1'b1, INT, 13, 12, 2); set1(1'b1, INT, 14, 2, 2);
    expect_issue("R9 slot0 consumer waits", 1'b0, 1'b0);
    next_cycle();
    expect_issue("R11 consumer issues after gap", 1'b1, 1'b0);
    idle(); set0(1'b1, LD, 15, 1, 0);
    expect_issue("R9 second load issues", 1'b1, 1'b0);
    next_cycle(); set0(1'b1, ST, 0, 2, 3); set1(1'b1, INT, 16, 15, 2);
    expect_issue("R9 slot1 consumer held", 1'b1, 1'b0);
  endtask

  task automatic t_gap_with_stall();
    idle(); set0(1'b1, LD, 17, 1, 0);
    expect_issue("R11 load issues", 1'b1, 1'b0);
    next_cycle(); stall = 1'b1; set0(1'b1, INT, 18, 17, 0);
    expect_issue("R11 stall cycle", 1'b0, 1'b0);
    next_cycle(); stall = 1'b0;
    expect_issue("R11 stall counted in gap", 1'b1, 1'b0);
  endtask

  task automatic t_reset_clears();
    idle(); set0(1'b1, LD, 20, 1, 0);
    expect_issue("R1 load before reset", 1'b1, 1'b0);
    next_cycle();
    rst_n = 1'b0;
    set0(1'b1, INT, 21, 20, 0);
    expect_issue("R1 reset clears load record", 1'b1, 1'b0);
    set0(1'b0, INT, 0, 0, 0);
    #0.5 rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    stall = 1'b0;
    set0(1'b0, INT, 0, 0, 0);
    set1(1'b0, INT, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_state();
    t_stall();
    t_invalid_slots();
    t_classes();
    t_raw();
    t_waw();
    t_load_use();
    t_gap_with_stall();
    t_reset_clears();
    idle();
    expect_issue("R10 final idle", 1'b0, 1'b0);
    finish_run();
  end

endmodule